// File: doc/BRIEF.md
# Comparator Threshold Background Calibrator

This block holds two comparator offset thresholds in place while the circuit runs. It watches the decisions of an upper and a lower comparator. Over a fixed window of reference-rate clocks it counts how many times each one fired. At the end of every window it compares each count with a programmable target and moves the matching digital control word one step. The two control words feed fine-resolution delta-sigma DACs. Those DACs set the upper and lower threshold voltages that sit around a fixed middle reference.

The upper threshold is the upper DAC level minus the middle reference, so a larger upper word widens it. The lower threshold is the middle reference minus the lower DAC level, so a smaller lower word widens it. The two channels are servoed separately. Each word depends only on its own comparator and its own target. The loop never stops, so comparator offsets and DAC nonlinearity are absorbed, provided the DAC is monotonic.

Top module: `cmp_thresh_servo`

## Requirements
- R1: A synchronous reset loads both control words with mid-scale, 2^(CW-1), and clears the window counter and both event accumulators.
- R2: A window is 2^WIN_BITS consecutive clocks after reset release. The comparator inputs are sampled on every clock of the window, including its last one. The control words change only on the clock edge that closes a window, and never by more than one LSB.
- R3: If the upper event count of a window exceeds the upper target, the upper word increases by one LSB (widening).
- R4: If the upper event count is below the upper target, the upper word decreases by one LSB (narrowing).
- R5: If a count equals its target, the corresponding word is held unchanged. This includes the extremes of zero hits and hits on every clock.
- R6: If the lower event count exceeds the lower target, the lower word decreases by one LSB (widening).
- R7: If the lower event count is below the lower target, the lower word increases by one LSB (narrowing).
- R8: Both words saturate at 0 and at 2^CW-1 and never wrap.
- R9: Each word's update depends only on its own comparator input and its own target.
- R10: The accumulators restart from zero at every window, so no count carries into the next window. A reset in the middle of a window discards the partial counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_hit | input | 1 | Upper comparator decision, 1 = fired |
| lo_hit | input | 1 | Lower comparator decision, 1 = fired |
| hi_target | input | WIN_BITS+1 | Desired upper event count per window |
| lo_target | input | WIN_BITS+1 | Desired lower event count per window |
| hi_word | output | CW | Control word for the upper threshold DAC |
| lo_word | output | CW | Control word for the lower threshold DAC |

## Verification
The bench places a single hit on the very last clock of a window. A design that dropped the closing sample, or cleared the accumulator one cycle early, would leave the word unchanged there. It runs counts equal to the target at both extremes, 0 and a full window. An off-by-one compare would then drift the words, and it drives the two channels in opposite directions, which would expose a swapped sign on the lower word. It pushes both words against the rails for more windows than mid-scale needs, where a wrapping adder would jump from full scale to zero. It also resets in the middle of a heavily hit window, where leftover counts would corrupt the next decision.

// File: rtl/cmp_thresh_servo.sv
module cmp_thresh_servo #(
  parameter int WIN_BITS = 7,
  parameter int CW       = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hi_hit,
  input  logic                lo_hit,
  input  logic [WIN_BITS:0]   hi_target,
  input  logic [WIN_BITS:0]   lo_target,
  output logic [CW-1:0]       hi_word,
  output logic [CW-1:0]       lo_word
);
  localparam int CNTW = WIN_BITS + 1;
  localparam logic [CW-1:0] MID  = CW'(1) << (CW - 1);
  localparam logic [CW-1:0] MAXW = '1;

  logic [WIN_BITS-1:0] win;
  logic [CNTW-1:0]     hi_acc, lo_acc;
  logic [CNTW-1:0]     hi_sum, lo_sum;
  logic                win_end;

  assign win_end = &win;
  assign hi_sum  = hi_acc + CNTW'(hi_hit);
  assign lo_sum  = lo_acc + CNTW'(lo_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      win     <= '0;
      hi_acc  <= '0;
      lo_acc  <= '0;
      hi_word <= MID;
      lo_word <= MID;
    end else begin
      win <= win + 1'b1;
      if (win_end) begin
        hi_acc <= '0;
        lo_acc <= '0;
        if (hi_sum > hi_target && hi_word != MAXW)
          hi_word <= hi_word + 1'b1;
        else if (hi_sum < hi_target && hi_word != '0)
          hi_word <= hi_word - 1'b1;
        if (lo_sum > lo_target && lo_word != '0)
          lo_word <= lo_word - 1'b1;
        else if (lo_sum < lo_target && lo_word != MAXW)
          lo_word <= lo_word + 1'b1;
      end else begin
        hi_acc <= hi_sum;
        lo_acc <= lo_sum;
      end
    end
  end
endmodule

// File: rtl/cmp_thresh_servo_chk.sv
module cmp_thresh_servo_chk #(
  parameter int WIN_BITS = 7,
  parameter int CW       = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              win_end,
  input logic [WIN_BITS:0] hi_sum,
  input logic [WIN_BITS:0] lo_sum,
  input logic [WIN_BITS:0] hi_target,
  input logic [WIN_BITS:0] lo_target,
  input logic [CW-1:0]     hi_word,
  input logic [CW-1:0]     lo_word
);
  localparam logic [CW-1:0] MID  = CW'(1) << (CW - 1);
  localparam logic [CW-1:0] MAXW = '1;

  AST_RESET_MID: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (hi_word == MID && lo_word == MID)); // R1
  AST_HOLD_MIDWIN: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> ($stable(hi_word) && $stable(lo_word))); // R2
  AST_HI_WIDEN: assert property (@(posedge clk) disable iff (rst)
    (win_end && hi_sum > hi_target && hi_word != MAXW) |=> hi_word == $past(hi_word) + 1'b1); // R3
  AST_LO_WIDEN: assert property (@(posedge clk) disable iff (rst)
    (win_end && lo_sum > lo_target && lo_word != '0) |=> lo_word == $past(lo_word) - 1'b1); // R6
  AST_HI_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    hi_word == MAXW |=> hi_word != '0); // R8
  AST_LO_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    lo_word == '0 |=> lo_word != MAXW); // R8
endmodule

bind cmp_thresh_servo cmp_thresh_servo_chk #(.WIN_BITS(WIN_BITS), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .win_end(win_end), .hi_sum(hi_sum), .lo_sum(lo_sum),
  .hi_target(hi_target), .lo_target(lo_target), .hi_word(hi_word), .lo_word(lo_word)
);

// File: tb/test_cmp_thresh_servo.sv
module test_cmp_thresh_servo;
  localparam int WB  = 7;
  localparam int CW  = 5;
  localparam int WIN = 1 << WB;
  localparam int MID = 1 << (CW - 1);
  localparam int MX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi_hit = 1'b0, lo_hit = 1'b0;
  logic [WB:0] hi_target = '0, lo_target = '0;
  logic [CW-1:0] hi_word, lo_word;

  cmp_thresh_servo #(.WIN_BITS(WB), .CW(CW)) i_cmp_thresh_servo (
    .clk(clk), .rst(rst), .hi_hit(hi_hit), .lo_hit(lo_hit),
    .hi_target(hi_target), .lo_target(lo_target),
    .hi_word(hi_word), .lo_word(lo_word)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  int cur_hi = MID, cur_lo = MID;
  int mdl_hi = MID, mdl_lo = MID;
  int q_hi[$], q_lo[$];
  string q_tag[$];
  bit finished = 0;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pops one expected pair per closed window, else checks hold
  always @(negedge clk) begin
    if (!rst && cyc != 0) begin
      string tag;
      tag = "R2";
      if (cyc % WIN == 0 && q_hi.size() > 0) begin
        cur_hi = q_hi.pop_front();
        cur_lo = q_lo.pop_front();
        tag    = q_tag.pop_front();
      end
      check({tag, " hi_word"}, int'(hi_word), cur_hi);
      check({tag, " lo_word"}, int'(lo_word), cur_lo);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; hi_hit = 1'b0; lo_hit = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mdl_hi = MID; mdl_lo = MID; cur_hi = MID; cur_lo = MID;
    check("R1 hi_word", int'(hi_word), MID);
    check("R1 lo_word", int'(lo_word), MID);
  endtask

  // driver: mode 0 places hits first, mode 1 places them last in the window
  task automatic window(int hn, int hm, int ht, int ln, int lm, int lt, string tag);
    hi_target = (WB+1)'(ht);
    lo_target = (WB+1)'(lt);
    if (hn > ht) mdl_hi = (mdl_hi < MX) ? mdl_hi + 1 : MX;
    else if (hn < ht) mdl_hi = (mdl_hi > 0) ? mdl_hi - 1 : 0;
    if (ln > lt) mdl_lo = (mdl_lo > 0) ? mdl_lo - 1 : 0;
    else if (ln < lt) mdl_lo = (mdl_lo < MX) ? mdl_lo + 1 : MX;
    q_hi.push_back(mdl_hi); q_lo.push_back(mdl_lo); q_tag.push_back(tag);
    for (int i = 0; i < WIN; i++) begin
      hi_hit = (hm == 0) ? (i < hn) : (i >= WIN - hn);
      lo_hit = (lm == 0) ? (i < ln) : (i >= WIN - ln);
      @(negedge clk);
    end
    hi_hit = 1'b0; lo_hit = 1'b0;
  endtask

  initial begin
    do_reset();
    window(20, 0, 20, 20, 1, 20, "R5");
    window(30, 0, 20, 10, 0, 20, "R3 R7");
    window(10, 1, 20, 30, 1, 20, "R4 R6");
    window(WIN, 0, WIN, 0, 0, 0, "R5");
    window(1, 1, 0, 0, 0, 1, "R2");
    window(30, 0, 20, 20, 0, 20, "R9");
    window(20, 0, 20, 5, 0, 20, "R9");
    for (int k = 0; k < 20; k++) window(WIN, 0, 0, WIN, 0, 0, "R8");
    for (int k = 0; k < 20; k++) window(0, 0, WIN, 0, 0, WIN, "R8");
    // partial heavy window, then reset: counts must not survive
    for (int i = 0; i < 60; i++) begin
      hi_hit = 1'b1; lo_hit = 1'b1;
      @(negedge clk);
    end
    do_reset();
    window(20, 0, 20, 20, 0, 20, "R10");
    window(64, 1, 64, 64, 0, 64, "R10");
    repeat (2) @(negedge clk);
    wrap_up();
  end

  initial begin
    #(100000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    wrap_up();
  end
endmodule